// File: doc/BRIEF.md
# Synchronous Up/Down Binary Counter

This block is a four-bit synchronous binary counter that steps up or down by one on each rising clock edge. A load strobe copies a parallel data word into the count at the next edge in place of counting. Two active-low count enables must both be asserted for the count to move. When the counter is cascaded, the carry-gating enable of a stage is driven by the carry output of the stage below it.

The active-low carry output marks the terminal count for the selected direction: fifteen when counting up, zero when counting down. It is gated by the carry-gating enable. It is decoded combinationally, so a change of the direction input alone moves the carry without any clock edge. The block handles no streamed data: every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure. A synchronous reset, used only in simulation, clears the count. Outside simulation the count powers up undefined.

Top module: `updown_counter`

## Requirements
- R1: While `sim_rst` is high at a rising edge, `q` becomes 0 at that edge.
- R2: With `load_n` high and both `en_p_n` and `en_t_n` low, each edge adds one to `q` when `up_dn` is 1 and subtracts one when `up_dn` is 0.
- R3: With `load_n` low, the next edge sets `q` to `din`, whatever the enables and `up_dn` are. `din[0]` is the least significant bit.
- R4: The count wraps: 15 goes to 0 counting up, and 0 goes to 15 counting down.
- R5: With `load_n` high and either `en_p_n` or `en_t_n` high, `q` holds its value across the edge.
- R6: `carry_n` is 1 whenever `en_t_n` is 1.
- R7: With `en_t_n` low, `carry_n` is 0 exactly when `up_dn`=1 and `q`=15, or when `up_dn`=0 and `q`=0. Otherwise it is 1.
- R8: With `q` at 0 or 15, a change on `up_dn` alone changes `carry_n` within the same clock phase, with no edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| sim_rst | input | 1 | Synchronous clear, active high, for simulation only |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| load_n | input | 1 | Parallel load strobe, active low |
| en_p_n | input | 1 | Count enable, active low |
| en_t_n | input | 1 | Count enable that also gates the carry, active low |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal-count carry, active low |

## Verification
A table of vectors exercises the counter under four input patterns: load, count up, count down and hold. The patterns include wraps in both directions, each enable disabled on its own, and loads issued while the enables are active, which shows that load wins over counting. The enable-disabled rows also show that disabling only the count-only enable still leaves the carry live, while disabling the carry-gating enable forces the carry inactive. Directed tests toggle the direction input at 0 and at 15 between clock edges to show the combinational carry path, and apply reset from a nonzero count.

// File: rtl/updown_pkg.sv
package updown_pkg;

  // Operation chosen for the coming clock edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/ud_ctrl.sv
module ud_ctrl
  import updown_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p_n,
  input  logic    en_t_n,
  input  logic    up_dn,
  output cnt_op_e op
);

  logic both_en;

  assign both_en = ~en_p_n & ~en_t_n;

  // Load outranks counting; counting needs both enables
  always_comb begin
    if (!load_n)      op = OP_LOAD;
    else if (!both_en) op = OP_HOLD;
    else if (up_dn)   op = OP_INC;
    else              op = OP_DEC;
  end

endmodule

// File: rtl/ud_next.sv
module ud_next
  import updown_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_INC:  nxt = cur + ONE;
      OP_DEC:  nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/ud_state.sv
module ud_state #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             sim_rst,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic             up_dn,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (sim_rst) q <= '0;
    else         q <= nxt;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    sim_rst |=> (q == '0));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (sim_rst)
    !load_n |=> (q == $past(din)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (sim_rst)
    (load_n && (en_p_n || en_t_n)) |=> $stable(q));

  // R2 R4
  count_up_chk: assert property (@(posedge clk) disable iff (sim_rst)
    (load_n && !en_p_n && !en_t_n && up_dn) |=> (q == WIDTH'($past(q) + 1'b1)));

  // R2 R4
  count_dn_chk: assert property (@(posedge clk) disable iff (sim_rst)
    (load_n && !en_p_n && !en_t_n && !up_dn) |=> (q == WIDTH'($past(q) - 1'b1)));

endmodule

// File: rtl/ud_carry.sv
module ud_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             up_dn,
  input  logic             en_t_n,
  output logic             carry_n
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  logic at_top;
  logic at_bot;
  logic term;

  assign at_top  = (q == TOP);
  assign at_bot  = (q == BOT);
  assign term    = up_dn ? at_top : at_bot;
  assign carry_n = ~(~en_t_n & term);

endmodule

// File: rtl/updown_counter.sv
module updown_counter
  import updown_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             sim_rst,
  input  logic             up_dn,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_n
);

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;

  ud_ctrl u_ctrl (
    .load_n (load_n),
    .en_p_n (en_p_n),
    .en_t_n (en_t_n),
    .up_dn  (up_dn),
    .op     (op)
  );

  ud_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (nxt)
  );

  ud_state #(.WIDTH(WIDTH)) u_state (
    .clk     (clk),
    .sim_rst (sim_rst),
    .load_n  (load_n),
    .en_p_n  (en_p_n),
    .en_t_n  (en_t_n),
    .up_dn   (up_dn),
    .din     (din),
    .nxt     (nxt),
    .q       (q)
  );

  ud_carry #(.WIDTH(WIDTH)) u_carry (
    .q       (q),
    .up_dn   (up_dn),
    .en_t_n  (en_t_n),
    .carry_n (carry_n)
  );

  // R6
  carry_gate_chk: assert property (@(posedge clk) disable iff (sim_rst)
    en_t_n |-> carry_n);

  // R7
  carry_top_chk: assert property (@(posedge clk) disable iff (sim_rst)
    (!en_t_n && up_dn && (q == {WIDTH{1'b1}})) |-> !carry_n);

  // R7
  carry_bot_chk: assert property (@(posedge clk) disable iff (sim_rst)
    (!en_t_n && !up_dn && (q == '0)) |-> !carry_n);

  // R7
  carry_idle_chk: assert property (@(posedge clk) disable iff (sim_rst)
    (q != '0 && q != {WIDTH{1'b1}}) |-> carry_n);

endmodule

// File: tb/updown_counter_bench.sv
`timescale 1ns/1ps
module updown_counter_bench;

  logic       clk = 1'b0;
  logic       sim_rst;
  logic       up_dn, load_n, en_p_n, en_t_n;
  logic [3:0] din;
  logic [3:0] q;
  logic       carry_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updown_counter u_updown_counter (
    .clk(clk), .sim_rst(sim_rst), .up_dn(up_dn), .load_n(load_n),
    .en_p_n(en_p_n), .en_t_n(en_t_n), .din(din), .q(q), .carry_n(carry_n)
  );

  typedef struct packed {
    logic       ld_n;
    logic       p_n;
    logic       t_n;
    logic       up;
    logic [3:0] d;
    logic [3:0] eq;
    logic       ec;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd14, 4'd14, 1'b1},  // load with enables off
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd15, 1'b0},  // up to top, carry live
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd0,  1'b1},  // wrap up
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd15, 1'b1},  // wrap down
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd14, 1'b1},  // down
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd14, 1'b1},  // hold, p off
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'd0,  4'd14, 1'b1},  // hold, t off
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd1,  4'd1,  1'b1},  // load beats count
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},  // down to bottom
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},  // p off, carry still live
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  4'd0,  1'b1},  // t off gates carry
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'd15, 4'd15, 1'b0}   // load top, carry up
  };

  function automatic string row_tag(int i);
    case (i)
      0:  return "R3 R6";
      1:  return "R2 R7";
      2:  return "R4 R7";
      3:  return "R4 R7";
      4:  return "R2";
      5:  return "R5";
      6:  return "R5 R6";
      7:  return "R3";
      8:  return "R2 R7";
      9:  return "R5 R7";
      10: return "R5 R6";
      default: return "R3 R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    sim_rst = 1'b1; up_dn = 1'b1; load_n = 1'b1;
    en_p_n = 1'b1; en_t_n = 1'b1; din = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    sim_rst = 1'b0;
    chk("R1 reset q", q, 4'd0);
    chk("R6 reset carry", {3'b0, carry_n}, 4'd1);

    for (int i = 0; i < NV; i++) begin
      load_n = VEC[i].ld_n; en_p_n = VEC[i].p_n; en_t_n = VEC[i].t_n;
      up_dn = VEC[i].up; din = VEC[i].d;
      @(posedge clk);
      @(negedge clk);
      chk({row_tag(i), " q"}, q, VEC[i].eq);
      chk({row_tag(i), " carry"}, {3'b0, carry_n}, {3'b0, VEC[i].ec});
    end

    // R8: q is 15, hold, toggle direction between edges
    load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b0; up_dn = 1'b1;
    #0.5;
    chk("R8 top up carry", {3'b0, carry_n}, 4'd0);
    up_dn = 1'b0;
    #0.5;
    chk("R8 top down carry", {3'b0, carry_n}, 4'd1);
    chk("R8 top hold q", q, 4'd15);

    // R8: load 0 then toggle direction at bottom
    @(negedge clk);
    load_n = 1'b0; din = 4'd0;
    @(posedge clk);
    @(negedge clk);
    load_n = 1'b1; up_dn = 1'b0;
    #0.5;
    chk("R8 bottom down carry", {3'b0, carry_n}, 4'd0);
    up_dn = 1'b1;
    #0.5;
    chk("R8 bottom up carry", {3'b0, carry_n}, 4'd1);

    // R1: reset from a nonzero count
    @(negedge clk);
    load_n = 1'b0; din = 4'd9;
    @(posedge clk);
    @(negedge clk);
    chk("R3 load nine", q, 4'd9);
    load_n = 1'b1; sim_rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sim_rst = 1'b0;
    chk("R1 reset from nine", q, 4'd0);

    done = 1;
    summary();
    $finish;
  end

endmodule